// File: doc/BRIEF.md
# Stretched Two-Phase Clock Generator

The block turns a fast master clock into the two non-overlapping phase clocks that a processor bus uses. The master runs at a whole multiple of the nominal phase rate. In a normal cycle one phase period spans that many master ticks. Phase 1 is high for the first half of the period and phase 2 for the second half. Two divided reference signals are also driven out. One is a square wave at the nominal phase rate, running all the time. The other is a half-rate square wave that toggles only during slow cycles.

A select input comes from the address decode of a slow peripheral bus. The block samples it only on the master edge that closes a phase cycle. When it is high there, the next cycle is a slow cycle. A slow cycle lasts two nominal periods. Phase 1 is high for the usual half period and phase 2 is high for the remaining one and a half periods, which gives the slow peripheral's data transfer more time. A cycle in progress is never cut short or lengthened.

Top module: `stretch_phase_clk`

## Requirements
- R1: While the synchronous reset is high, each master edge forces `phi1` to 1 and `phi2`, `ref_fast` and `ref_slow` to 0, and the next cycle is a normal one.
- R2: A normal cycle spans RATIO master ticks. `phi1` is high for the first RATIO/2 ticks and `phi2` is high for the last RATIO/2 ticks.
- R3: `ref_fast` is a square wave with a period of RATIO ticks. It is low for the first RATIO/2 ticks of each nominal period and high for the rest, and it keeps running in both normal and slow cycles.
- R4: A slow cycle spans 2*RATIO ticks. `phi1` is high for its first RATIO/2 ticks and `phi2` is high for the remaining 3*RATIO/2 ticks.
- R5: `ref_slow` is 0 throughout normal cycles. In a slow cycle it is 0 for the first RATIO ticks and 1 for the last RATIO ticks.
- R6: Exactly one of `phi1` and `phi2` is high on every tick. They are never high together.
- R7: `slow_sel` is sampled only on the master edge that ends a cycle, and the sampled value chooses the kind of the next cycle. Changes of `slow_sel` at any other time have no effect on the outputs.
- R8: RATIO is MASTER_HZ / PHASE_HZ (4 by default). It must be an even number of at least 2, so the measured `phi1` rise-to-rise spacing of a normal cycle is RATIO ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, RATIO times the nominal phase rate |
| rst | input | 1 | Synchronous active-high reset |
| slow_sel | input | 1 | Slow peripheral access select from the address decode |
| phi1 | output | 1 | Phase 1 clock |
| phi2 | output | 1 | Phase 2 clock |
| ref_fast | output | 1 | Square wave at the nominal phase rate |
| ref_slow | output | 1 | Half-rate square wave, active only in slow cycles |

## Verification
The bound checker watches the cycle-level invariants on every tick. It checks that the phases never overlap and that one of them is always high, and it checks the reset values. Using run-length counters, it also checks that each `phi1` pulse lasts half a period, that each `phi2` pulse lasts either half a period or one and a half periods, and that each `ref_slow` pulse lasts a full nominal period and falls within phase 2. These checks cannot tell whether a stretched cycle was the one actually requested, or whether a select toggled mid-cycle was correctly ignored. Only the bench shows that, by comparing its tick-level model against the outputs while `slow_sel` is held, toggled at odd offsets, and interrupted by a reset during a slow cycle.

// File: rtl/stretch_clk_pkg.sv
package stretch_clk_pkg;

    // Bundle of the four externally visible clock signals.
    typedef struct packed {
        logic phi1;
        logic phi2;
        logic ref_fast;
        logic ref_slow;
    } phase_out_t;

    // Divider-stage state handed from the slow stage to the encoder.
    typedef struct packed {
        logic slow;    // current cycle is a stretched one
        logic second;  // in the second nominal period of a stretched cycle
    } stretch_state_t;

    // Master ticks per nominal phase period.
    function automatic int tick_ratio(input int master_hz, input int phase_hz);
        return master_hz / phase_hz;
    endfunction

    // Width of a counter that must hold 0 .. n-1.
    function automatic int count_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sc_tick_div.sv
module sc_tick_div
    import stretch_clk_pkg::*;
#(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    output logic wrap,
    output logic upper_half
);
    localparam int CW   = count_width(RATIO);
    localparam int HALF = RATIO / 2;
    localparam logic [CW-1:0] LAST  = CW'(RATIO - 1);
    localparam logic [CW-1:0] HALFV = CW'(HALF);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wrap       = (cnt_q == LAST);
    assign upper_half = (cnt_q >= HALFV);
endmodule

// File: rtl/sc_stretch_div.sv
module sc_stretch_div
    import stretch_clk_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wrap,
    input  logic           slow_sel,
    output stretch_state_t st
);
    stretch_state_t st_q;
    logic           cycle_end;

    // A cycle ends at the last tick of a nominal period, unless a
    // stretched cycle still has its second period ahead.
    assign cycle_end = wrap && (!st_q.slow || st_q.second);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (cycle_end) begin
            st_q.slow   <= slow_sel;
            st_q.second <= 1'b0;
        end else if (wrap) begin
            st_q.second <= 1'b1;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/sc_phase_enc.sv
module sc_phase_enc
    import stretch_clk_pkg::*;
(
    input  logic           upper_half,
    input  stretch_state_t st,
    output phase_out_t     po
);
    always_comb begin
        po.ref_fast = upper_half;
        po.ref_slow = st.slow && st.second;
        po.phi1     = !po.ref_fast && !po.ref_slow;
        po.phi2     = !po.phi1;
    end
endmodule

// File: rtl/stretch_phase_clk.sv
module stretch_phase_clk
    import stretch_clk_pkg::*;
#(
    parameter int MASTER_HZ = 3_200_000,
    parameter int PHASE_HZ  = 800_000
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_sel,
    output logic phi1,
    output logic phi2,
    output logic ref_fast,
    output logic ref_slow
);
    localparam int RATIO = tick_ratio(MASTER_HZ, PHASE_HZ);

    // R8: ratio must split evenly into two phases
    generate
        if (RATIO < 2 || (RATIO % 2) != 0) begin : g_bad_ratio
            $error("stretch_phase_clk: tick ratio must be even and >= 2");
        end
    endgenerate

    logic           wrap;
    logic           upper_half;
    stretch_state_t st;
    phase_out_t     po;

    sc_tick_div #(.RATIO(RATIO)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .wrap       (wrap),
        .upper_half (upper_half)
    );

    sc_stretch_div u_stretch (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .slow_sel (slow_sel),
        .st       (st)
    );

    sc_phase_enc u_enc (
        .upper_half (upper_half),
        .st         (st),
        .po         (po)
    );

    assign phi1     = po.phi1;
    assign phi2     = po.phi2;
    assign ref_fast = po.ref_fast;
    assign ref_slow = po.ref_slow;
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
    parameter int RATIO = 4
) (
    input logic clk,
    input logic rst,
    input logic phi1,
    input logic phi2,
    input logic ref_fast,
    input logic ref_slow
);
    localparam int HALF = RATIO / 2;

    int p1_run, p2_run, rs_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            p1_run <= 0;
            p2_run <= 0;
            rs_run <= 0;
        end else begin
            p1_run <= phi1     ? p1_run + 1 : 0;
            p2_run <= phi2     ? p2_run + 1 : 0;
            rs_run <= ref_slow ? rs_run + 1 : 0;
        end
    end

    // R1
    reset_values_chk: assert property (@(posedge clk)
        rst |=> (phi1 && !phi2 && !ref_fast && !ref_slow));

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(phi1 && phi2));

    // R6
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({phi1, phi2}) == 1);

    // R2
    phi1_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!phi1 && $past(phi1)) |-> (p1_run == HALF));

    // R4
    phi2_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!phi2 && $past(phi2)) |-> (p2_run == HALF || p2_run == 3 * HALF));

    // R5
    slow_ref_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_slow && $past(ref_slow)) |-> (rs_run == RATIO));

    // R5
    slow_ref_in_phi2_chk: assert property (@(posedge clk) disable iff (rst)
        ref_slow |-> phi2);

    // R4
    stretch_hand_back_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(phi2) |-> phi1);
endmodule

bind stretch_phase_clk sc_checker #(.RATIO(RATIO)) u_sc_checker (
    .clk      (clk),
    .rst      (rst),
    .phi1     (phi1),
    .phi2     (phi2),
    .ref_fast (ref_fast),
    .ref_slow (ref_slow)
);

// File: tb/test_stretch_phase_clk.sv
module test_stretch_phase_clk;
    localparam int M = 3_200_000 / 800_000;
    localparam int H = M / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0;
    logic phi1, phi2, ref_fast, ref_slow;

    int    errors = 0;
    int    checks = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    // Behavioural reference: position in the current cycle and its length.
    int pos    = 0;
    int len    = M;
    bit slow_m = 1'b0;

    always #2.5 clk = ~clk;

    stretch_phase_clk i_stretch_phase_clk (
        .clk      (clk),
        .rst      (rst),
        .slow_sel (sel),
        .phi1     (phi1),
        .phi2     (phi2),
        .ref_fast (ref_fast),
        .ref_slow (ref_slow)
    );

    always @(posedge clk) begin
        if (rst) begin
            pos    = 0;
            len    = M;
            slow_m = 1'b0;
        end else begin
            pos = pos + 1;
            if (pos == len) begin
                pos    = 0;
                slow_m = sel;
                len    = sel ? 2 * M : M;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual=%0d expected=%0d at %0t", req, tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int e1;
        e1 = (pos < H) ? 1 : 0;
        chk(slow_m ? "R4" : "R2", "phi1", int'(phi1), e1);
        chk(slow_m ? "R4" : "R2", "phi2", int'(phi2), 1 - e1);
        chk("R3", "ref_fast", int'(ref_fast), ((pos % M) >= H) ? 1 : 0);
        chk("R5", "ref_slow", int'(ref_slow), (slow_m && pos >= M) ? 1 : 0);
        chk("R6", "overlap", int'(phi1 && phi2), 0);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            compare();
        end
    endtask

    // R8: spacing between two phi1 rises in normal operation
    task automatic measure_period();
        logic prev;
        int   gap;
        prev = phi1;
        for (int i = 0; i < 4 * M; i++) begin
            @(negedge clk);
            compare();
            if (phi1 && !prev) break;
            prev = phi1;
        end
        gap  = 0;
        prev = phi1;
        for (int i = 0; i < 4 * M; i++) begin
            @(negedge clk);
            compare();
            gap++;
            if (phi1 && !prev) break;
            prev = phi1;
        end
        chk("R8", "phi1 period", gap, M);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        // R1: reset state
        tag = "R1";
        step(3);
        rst = 1'b0;

        // R2, R3: normal cycles with select low
        tag = "R2";
        step(4 * M);

        tag = "R8";
        measure_period();

        // R4, R5: select held high, stretched cycles
        sel = 1'b1;
        tag = "R4";
        step(6 * M);

        // R7: select toggled at offsets unrelated to cycle boundaries
        tag = "R7";
        for (int k = 0; k < 40; k++) begin
            sel = (((k * 7) % 5) < 2);
            step(3);
        end
        for (int k = 0; k < 20; k++) begin
            sel = ~sel;
            step(1);
        end

        sel = 1'b0;
        tag = "R2";
        step(3 * M);

        // R1: reset in the middle of a stretched cycle
        sel = 1'b1;
        step(3 * M + 1);
        rst = 1'b1;
        tag = "R1";
        step(2);
        rst = 1'b0;
        tag = "R5";
        step(6 * M);

        summary();
    end
endmodule